// File: doc/BRIEF.md
# Write-Priority Single-Port Buffer Level

This block is one stage of an on-demand streaming memory hierarchy that feeds an accelerator's compute units. An upstream fill stream writes words into a small RAM, and a downstream consumer issues read requests by address. Every entry carries an occupancy flag. A write sets the flag and the read that consumes the word clears it, so the level can be refilled as a circular buffer while data flows through it.

In the default single-ported variant, one RAM address port serves both streams. An internal port-operation select picks the write address in a write cycle and the read address in a read cycle. A write always wins, and a read that collides with it waits for a later cycle. A read of an entry that has not been filled stalls until the write to that entry arrives, so stale data is never returned. When the read is issued, the word appears one cycle later together with a valid strobe. With the dual-ported option the arbitration is removed: reads and writes go through separate address buses and can complete in the same cycle.

Top module: `wb_buf_level`

## Requirements
- R1: A write is accepted (`wr_ready` high) whenever the addressed entry is empty, and the accepted word is stored at that address.
- R2: An issued read (`rd_valid` and `rd_ready` high at a rising edge) produces `rdata_valid` high after exactly one clock edge, and `rdata` then equals the last word written to that address.
- R3: In single-ported mode (`DUAL_PORT`=0), when a write is accepted in a cycle, `rd_ready` is low in that cycle. The read is deferred and can be issued in a later cycle.
- R4: A read request to an empty entry keeps `rd_ready` low until a write to that entry has been accepted.
- R5: An issued read empties its entry. A second read of that address stalls, and a new write to it is accepted.
- R6: A write to an entry that is occupied and not yet read is back-pressured with `wr_ready` low.
- R7: In dual-ported mode (`DUAL_PORT`=1), `rd_ready` depends only on the occupancy of the read address, so a read and a write to different addresses both complete in the same cycle.
- R8: A synchronous active-high reset empties all entries. After reset `rd_ready` is low for every address, `wr_ready` is high, and `rdata_valid` is low.
- R9: `rdata_valid` is low in any cycle that does not follow an issued read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted this cycle |
| wr_addr | input | AW | Write address |
| wr_data | input | DATA_W | Write data |
| rd_valid | input | 1 | Read request |
| rd_ready | output | 1 | Read issued this cycle |
| rd_addr | input | AW | Read address |
| rdata_valid | output | 1 | Read data strobe, one cycle after issue |
| rdata | output | DATA_W | Read data |

## Verification
A single-ported instance and a dual-ported instance receive identical stimulus and are compared against per-instance occupancy and data models.

Directed sequences cover three cases:
- The reset state.
- A write that collides with a read of an already filled entry. The single-ported instance must stall the read while the dual-ported one completes it.
- A read of an empty entry that the write arriving later releases.

Random traffic is confined to a few addresses so that collisions, rereads after consumption and rewrites of occupied entries happen often. This separates back-pressure on occupied entries from stalls on empty ones and from stalls caused by write priority. Each issued read's returned word is compared with the model, which catches a wrong address mux or stale data.

// File: rtl/wb_pkg.sv
package wb_pkg;
   // Port operation select: 0 = read cycle, 1 = write cycle
   typedef enum logic {
      OP_READ  = 1'b0,
      OP_WRITE = 1'b1
   } port_op_e;
endpackage

// File: rtl/wb_valid_track.sv
module wb_valid_track #(
   parameter int DEPTH = 16,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             set_en,
   input  logic [AW-1:0]    set_addr,
   input  logic             clr_en,
   input  logic [AW-1:0]    clr_addr,
   output logic [DEPTH-1:0] occ
);
   // One occupancy flag per entry: set on write, cleared on consuming read
   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic hit_set, hit_clr;
      assign hit_set = set_en && (set_addr == AW'(i));
      assign hit_clr = clr_en && (clr_addr == AW'(i));
      always_ff @(posedge clk) begin
         if (rst)
            occ[i] <= 1'b0;
         else if (hit_set)
            occ[i] <= 1'b1;
         else if (hit_clr)
            occ[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/wb_port_arb.sv
module wb_port_arb
   import wb_pkg::*;
#(
   parameter bit DUAL_PORT = 1'b0
) (
   input  logic     rst,
   input  logic     wr_valid,
   input  logic     wr_slot_free,
   input  logic     rd_slot_full,
   output logic     wr_go,
   output logic     rd_ok,
   output port_op_e sel
);
   assign wr_go = !rst && wr_valid && wr_slot_free;

   if (DUAL_PORT) begin : g_dual
      // Separate buses: no sharing, read depends only on occupancy
      assign rd_ok = !rst && rd_slot_full;
      assign sel   = OP_READ;
   end else begin : g_single
      // Shared port: an accepted write claims the cycle
      assign sel   = wr_go ? OP_WRITE : OP_READ;
      assign rd_ok = !rst && rd_slot_full && (sel == OP_READ);
   end
endmodule

// File: rtl/wb_ram.sv
module wb_ram
   import wb_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int DATA_W    = 16,
   parameter bit DUAL_PORT = 1'b0,
   parameter int AW        = $clog2(DEPTH)
) (
   input  logic              clk,
   input  port_op_e          sel,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] q
);
   logic [DATA_W-1:0] mem [DEPTH];

   if (DUAL_PORT) begin : g_dual
      always_ff @(posedge clk) begin
         if (we) mem[waddr] <= wdata;
         if (re) q <= mem[raddr];
      end
   end else begin : g_single
      logic [AW-1:0] port_addr;
      assign port_addr = (sel == OP_WRITE) ? waddr : raddr;
      always_ff @(posedge clk) begin
         if (sel == OP_WRITE) begin
            if (we) mem[port_addr] <= wdata;
         end else if (re) begin
            q <= mem[port_addr];
         end
      end
   end
endmodule

// File: rtl/wb_buf_level.sv
module wb_buf_level
   import wb_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int DATA_W    = 16,
   parameter bit DUAL_PORT = 1'b0,
   localparam int AW       = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_valid,
   output logic              rd_ready,
   input  logic [AW-1:0]     rd_addr,
   output logic              rdata_valid,
   output logic [DATA_W-1:0] rdata
);
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_chk_depth
      $error("DEPTH must be a power of two >= 2");
   end
   if (DATA_W < 1) begin : g_chk_width
      $error("DATA_W must be positive");
   end

   logic [DEPTH-1:0] occ;
   logic             wr_go, rd_ok, rd_go;
   port_op_e         sel;

   wb_port_arb #(.DUAL_PORT(DUAL_PORT)) u_arb (
      .rst          (rst),
      .wr_valid     (wr_valid),
      .wr_slot_free (!occ[wr_addr]),
      .rd_slot_full (occ[rd_addr]),
      .wr_go        (wr_go),
      .rd_ok        (rd_ok),
      .sel          (sel)
   );

   assign wr_ready = wr_go || (!rst && !occ[wr_addr]);
   assign rd_ready = rd_ok;
   assign rd_go    = rd_valid && rd_ok;

   wb_valid_track #(.DEPTH(DEPTH)) u_occ (
      .clk      (clk),
      .rst      (rst),
      .set_en   (wr_go),
      .set_addr (wr_addr),
      .clr_en   (rd_go),
      .clr_addr (rd_addr),
      .occ      (occ)
   );

   wb_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DUAL_PORT(DUAL_PORT)) u_ram (
      .clk   (clk),
      .sel   (sel),
      .we    (wr_go),
      .waddr (wr_addr),
      .wdata (wr_data),
      .re    (rd_go),
      .raddr (rd_addr),
      .q     (rdata)
   );

   always_ff @(posedge clk) begin
      if (rst) rdata_valid <= 1'b0;
      else     rdata_valid <= rd_go;
   end
endmodule

// File: rtl/wb_buf_level_chk.sv
module wb_buf_level_chk #(
   parameter int AW        = 4,
   parameter bit DUAL_PORT = 1'b0
) (
   input logic          clk,
   input logic          rst,
   input logic          wr_valid,
   input logic          wr_ready,
   input logic [AW-1:0] wr_addr,
   input logic          rd_valid,
   input logic          rd_ready,
   input logic          rdata_valid
);
   // R3: an accepted write keeps the shared port from the read
   p_wr_first_r3: assert property (@(posedge clk) disable iff (rst)
      (!DUAL_PORT && wr_valid && wr_ready) |-> !rd_ready);

   // R2: data strobe one cycle after issue
   p_rdv_issue_r2: assert property (@(posedge clk) disable iff (rst)
      (rd_valid && rd_ready) |=> rdata_valid);

   // R9: no strobe without a preceding issue
   p_rdv_only_r9: assert property (@(posedge clk) disable iff (rst)
      !(rd_valid && rd_ready) |=> !rdata_valid);

   // R6: an entry just written refuses a second write
   p_block_rewrite_r6: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && wr_ready) |=> (wr_addr != $past(wr_addr)) || !wr_ready);

   // R8: first cycle after reset: everything empty
   p_reset_empty_r8: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!rd_ready && wr_ready && !rdata_valid));
endmodule

bind wb_buf_level wb_buf_level_chk #(.AW(AW), .DUAL_PORT(DUAL_PORT)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .wr_valid    (wr_valid),
   .wr_ready    (wr_ready),
   .wr_addr     (wr_addr),
   .rd_valid    (rd_valid),
   .rd_ready    (rd_ready),
   .rdata_valid (rdata_valid)
);

// File: tb/tb_wb_buf_level.sv
`timescale 1ns/1ps
module tb_wb_buf_level;
   localparam int DEPTH = 16;
   localparam int DW    = 16;
   localparam int AW    = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wv = 1'b0, rv = 1'b0;
   logic [AW-1:0] wa = '0, ra = '0;
   logic [DW-1:0] wd = '0;
   logic [1:0]    wrr, rdr, rdv;
   logic [DW-1:0] rdt [2];

   int tests = 0, fails = 0;

   // model per instance: k=0 single-ported, k=1 dual-ported
   bit            mv   [2][DEPTH];
   logic [DW-1:0] md   [2][DEPTH];
   bit            pend [2];
   logic [DW-1:0] pdat [2];

   always #2 clk = ~clk;  // 250 MHz

   wb_buf_level #(.DEPTH(DEPTH), .DATA_W(DW), .DUAL_PORT(1'b0)) dut (
      .clk(clk), .rst(rst), .wr_valid(wv), .wr_ready(wrr[0]), .wr_addr(wa),
      .wr_data(wd), .rd_valid(rv), .rd_ready(rdr[0]), .rd_addr(ra),
      .rdata_valid(rdv[0]), .rdata(rdt[0]));

   wb_buf_level #(.DEPTH(DEPTH), .DATA_W(DW), .DUAL_PORT(1'b1)) dut_dp (
      .clk(clk), .rst(rst), .wr_valid(wv), .wr_ready(wrr[1]), .wr_addr(wa),
      .wr_data(wd), .rd_valid(rv), .rd_ready(rdr[1]), .rd_addr(ra),
      .rdata_valid(rdv[1]), .rdata(rdt[1]));

   task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit exp_rd(int k, bit w, logic [AW-1:0] wadr,
                                 bit r, logic [AW-1:0] radr);
      bit wgo = w && !mv[k][wadr];
      return mv[k][radr] && !(k == 0 && wgo);
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; wv = 1'b0; rv = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      for (int k = 0; k < 2; k++) begin
         pend[k] = 1'b0;
         for (int i = 0; i < DEPTH; i++) mv[k][i] = 1'b0;
      end
   endtask

   // one cycle: check last read's data, drive, check readies, advance model
   task automatic step(bit w, logic [AW-1:0] wadr, logic [DW-1:0] wdat,
                       bit r, logic [AW-1:0] radr);
      @(negedge clk);
      for (int k = 0; k < 2; k++) begin
         if (pend[k]) begin
            check("R2 rdata_valid", DW'(rdv[k]), DW'(1));
            check("R2 rdata", rdt[k], pdat[k]);
         end else begin
            check("R9 rdata_valid idle", DW'(rdv[k]), DW'(0));
         end
      end
      wv = w; wa = wadr; wd = wdat; rv = r; ra = radr;
      #1;
      for (int k = 0; k < 2; k++) begin
         bit ew  = !mv[k][wadr];
         bit er  = exp_rd(k, w, wadr, r, radr);
         bit wgo = w && ew;
         bit rgo = r && er;
         check(ew ? "R1 wr_ready empty" : "R6 wr_ready occupied", DW'(wrr[k]), DW'(ew));
         if (k == 1)
            check("R7 rd_ready dual", DW'(rdr[k]), DW'(er));
         else if (mv[k][radr] && wgo)
            check("R3 rd_ready write priority", DW'(rdr[k]), DW'(er));
         else
            check(mv[k][radr] ? "R5 rd_ready full" : "R4 rd_ready empty", DW'(rdr[k]), DW'(er));
         pend[k] = rgo;
         pdat[k] = md[k][radr];
         if (rgo) mv[k][radr] = 1'b0;
         if (wgo) begin
            mv[k][wadr] = 1'b1;
            md[k][wadr] = wdat;
         end
      end
   endtask

   initial begin
      #(4 * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int seed = 32'h5eed_1234;
      void'($urandom(seed));
      do_reset();
      // R8: reset state
      @(negedge clk);
      for (int k = 0; k < 2; k++) begin
         check("R8 rd_ready after reset", DW'(rdr[k]), DW'(0));
         check("R8 wr_ready after reset", DW'(wrr[k]), DW'(1));
         check("R8 rdata_valid after reset", DW'(rdv[k]), DW'(0));
      end
      // R4: read of empty entry stalls, then released by write
      step(1'b0, 4'd0, 16'h0, 1'b1, 4'd5);
      step(1'b1, 4'd5, 16'hA5A5, 1'b1, 4'd5);
      step(1'b0, 4'd0, 16'h0, 1'b1, 4'd5);
      // R3/R7: collision of a write with a read of a full entry
      step(1'b1, 4'd2, 16'h1234, 1'b0, 4'd0);
      step(1'b1, 4'd3, 16'h5678, 1'b1, 4'd2);
      step(1'b0, 4'd0, 16'h0, 1'b1, 4'd2);
      // R5: reread stalls, rewrite accepted; R6: double write blocked
      step(1'b1, 4'd2, 16'hBEEF, 1'b1, 4'd2);
      step(1'b1, 4'd3, 16'hDEAD, 1'b0, 4'd0);
      // random traffic on a few addresses
      for (int n = 0; n < 3000; n++) begin
         step(1'($urandom_range(0, 1)), AW'($urandom_range(0, 3)),
              DW'($urandom),
              1'($urandom_range(0, 1)), AW'($urandom_range(0, 3)));
      end
      // R8: mid-run reset empties everything
      do_reset();
      for (int i = 0; i < 4; i++) step(1'b0, AW'(i), 16'h0, 1'b1, AW'(i));
      step(1'b0, 4'd0, 16'h0, 1'b0, 4'd0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule